// File: doc/BRIEF.md
# Windowed Profile Table Port

This block lets a host on a byte-wide bus fill and read back a small table of 10-bit words through only four bus addresses. The table holds a power-ramp profile that a separate DAC sequencer plays out. A 4-bit block pointer chooses which group of four byte locations the window currently shows. Each 10-bit word uses two adjacent window addresses. The even address holds the two least significant bits and the odd address holds the upper eight bits.

The host first sets the enable input. It then walks the whole table by accessing the four window addresses over and over. An access to the top window address moves the pointer to the next block. The access direction that moves it is chosen by a mode input: reads or writes. Once the pointer has moved past the last block, the port locks out further accesses and raises a sticky overflow flag. Clearing the enable input rewinds the pointer to zero and clears the flag.

A second port reads the table by word index for the DAC sequencer. It has no influence on the host side.

Top module: `tbl_win_port`

## Requirements
- R1: A host access selects table word {ptr, bus_addr[1]}. Addresses 0 and 1 reach word 2·ptr, and addresses 2 and 3 reach word 2·ptr+1.
- R2: A write to an even address (bus_addr[0]=0) stores bus_wdata[1:0] in a holding register. A write to an odd address writes {bus_wdata[7:0], held bits} into the selected word as one 10-bit value.
- R3: While io_en is 0, the pointer is 0 and host accesses are ignored: writes leave the table unchanged and reads return 0.
- R4: With rd_inc=0, a write to address 3 advances the pointer by one block. A read of address 3 leaves the pointer unchanged.
- R5: With rd_inc=1, a read of address 3 advances the pointer by one block. A write to address 3 leaves the pointer unchanged.
- R6: A valid read returns its data on bus_rdata in the cycle after the strobe. An even address returns {6'b0, word[1:0]} and an odd address returns word[9:2]. In every other cycle bus_rdata is 0.
- R7: An advancing access while the pointer is 15 sets ovf. While ovf is 1, host writes are ignored and host reads return 0. ovf stays 1 until io_en goes to 0, which clears it within one cycle.
- R8: seq_data shows table word seq_idx one cycle after seq_idx is sampled. In a cycle with an accepted host access, seq_data holds its previous value.
- R9: After reset, ovf, bus_rdata and seq_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_en | input | 1 | Window enable; 0 rewinds pointer and clears ovf |
| rd_inc | input | 1 | 1: reads of address 3 advance; 0: writes do |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Window address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, one cycle after strobe |
| ovf | output | 1 | Sticky pointer overflow |
| seq_idx | input | 5 | Sequencer word index |
| seq_data | output | 10 | Sequencer word, one cycle after index |

## Verification
Both read paths have one cycle of latency. Host read data appears in the cycle after the strobe, and sequencer data appears one cycle after the index is sampled. Pointer and overflow changes show up on the access that follows the advancing one. The bench drives every stimulus on a falling edge and samples at the next falling edge, so exactly one rising edge separates cause and observation. Pointer movement is checked only through the data later accesses return, and the RAM contents are checked through the sequencer port.

// File: rtl/tbl_win_pkg.sv
// Shared definitions for the windowed profile table port.
// Assumes a four-location window addressed by two bits.
package tbl_win_pkg;
    localparam int WIN_AW = 2;
    typedef enum logic [WIN_AW-1:0] {
        SLOT_LO_A = 2'd0,
        SLOT_HI_A = 2'd1,
        SLOT_LO_B = 2'd2,
        SLOT_HI_B = 2'd3
    } win_slot_e;
endpackage

// File: rtl/tbl_blk_ptr.sv
// Block pointer with sticky overflow.
// Assumes adv_i is asserted only for accepted accesses that advance the pointer.
module tbl_blk_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_en,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             ovf_o
);
    localparam logic [PTR_W-1:0] PTR_LAST = {PTR_W{1'b1}};

    logic [PTR_W-1:0] ptr_q;
    logic             ovf_q;

    // Advance, saturate at the last block and latch overflow; disable rewinds.
    always_ff @(posedge clk) begin
        if (!rst_n || !io_en) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
        end else if (adv_i) begin
            if (ptr_q == PTR_LAST) ovf_q <= 1'b1;
            else                   ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;
    assign ovf_o = ovf_q;

    AST_PTR_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |=> (ptr_q == '0)); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && !adv_i) |=> (ptr_q == $past(ptr_q))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && io_en) |=> ovf_q); // R7
endmodule

// File: rtl/tbl_word_io.sv
// Splits and assembles table words for the byte bus.
// Assumes act_i is already gated by enable and overflow.
module tbl_word_io #(
    parameter int LO_W = 2,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_i,
    input  logic                 wr_i,
    input  logic                 odd_i,
    input  logic [HI_W-1:0]      wdata_i,
    input  logic [LO_W+HI_W-1:0] ram_rdata_i,
    output logic                 ram_we_o,
    output logic [LO_W+HI_W-1:0] ram_wdata_o,
    output logic [HI_W-1:0]      rdata_o
);
    localparam int DATA_W = LO_W + HI_W;

    logic [LO_W-1:0]   stage_q;
    logic              rsp_q;
    logic              rsp_hi_q;
    logic [DATA_W-1:0] rword_q;

    // Hold the low bits written at an even address.
    always_ff @(posedge clk) begin
        if (!rst_n)                        stage_q <= '0;
        else if (act_i && wr_i && !odd_i)  stage_q <= wdata_i[LO_W-1:0];
    end

    // Capture the read word and mark the following cycle as a response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q    <= 1'b0;
            rsp_hi_q <= 1'b0;
            rword_q  <= '0;
        end else begin
            rsp_q    <= act_i && !wr_i;
            rsp_hi_q <= odd_i;
            if (act_i && !wr_i) rword_q <= ram_rdata_i;
        end
    end

    // Commit a full word on an odd-address write.
    always_comb begin
        ram_we_o    = act_i && wr_i && odd_i;
        ram_wdata_o = {wdata_i, stage_q};
    end

    // Format the response byte; zero outside a response cycle.
    always_comb begin
        if (!rsp_q)        rdata_o = '0;
        else if (rsp_hi_q) rdata_o = rword_q[DATA_W-1:LO_W];
        else               rdata_o = {{(HI_W-LO_W){1'b0}}, rword_q[LO_W-1:0]};
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_q && !rsp_hi_q) |-> (rdata_o[HI_W-1:LO_W] == '0)); // R6
endmodule

// File: rtl/tbl_ram.sv
// Profile table storage: one synchronous write port, one asynchronous read.
// Assumes a single address is shared by write and read.
module tbl_ram #(
    parameter int DATA_W = 10,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store a word on write enable.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[idx_i] <= wdata_i;
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/tbl_win_port.sv
// Top of the windowed profile table port: host window plus sequencer read.
// Assumes one host access per strobed cycle; host wins the shared RAM port.
module tbl_win_port
    import tbl_win_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int LO_W  = 2,
    parameter int HI_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_en,
    input  logic                 rd_inc,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [WIN_AW-1:0]    bus_addr,
    input  logic [HI_W-1:0]      bus_wdata,
    output logic [HI_W-1:0]      bus_rdata,
    output logic                 ovf,
    input  logic [PTR_W:0]       seq_idx,
    output logic [LO_W+HI_W-1:0] seq_data
);
    localparam int DATA_W = LO_W + HI_W;
    localparam int IDX_W  = PTR_W + 1;

    logic [PTR_W-1:0]  ptr;
    logic              host_act;
    logic              adv;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_idx;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] seq_q;

    // Accept host accesses only while enabled and not overflowed.
    always_comb begin
        host_act = bus_sel && io_en && !ovf;
        adv      = host_act && (win_slot_e'(bus_addr) == SLOT_HI_B) && (bus_wr != rd_inc);
        ram_idx  = host_act ? {ptr, bus_addr[1]} : seq_idx;
    end

    tbl_blk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .io_en (io_en),
        .adv_i (adv),
        .ptr_o (ptr),
        .ovf_o (ovf)
    );

    tbl_word_io #(.LO_W(LO_W), .HI_W(HI_W)) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (host_act),
        .wr_i        (bus_wr),
        .odd_i       (bus_addr[0]),
        .wdata_i     (bus_wdata),
        .ram_rdata_i (ram_rdata),
        .ram_we_o    (ram_we),
        .ram_wdata_o (ram_wdata),
        .rdata_o     (bus_rdata)
    );

    tbl_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .idx_i   (ram_idx),
        .wdata_i (ram_wdata),
        .rdata_o (ram_rdata)
    );

    // Register the sequencer word when the host leaves the RAM port free.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_q <= '0;
        else if (!host_act) seq_q <= ram_rdata;
    end

    assign seq_data = seq_q;

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && io_en && !ovf) |=> $stable(seq_data)); // R8
    AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (!io_en || ovf)) |=> (bus_rdata == '0)); // R7
endmodule

// File: tb/sim_tbl_win_port.sv
module sim_tbl_win_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_en = 1'b0;
    logic       rd_inc = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ovf;
    logic [4:0] seq_idx = '0;
    logic [9:0] seq_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [9:0] model [32];

    always #5 clk = ~clk;

    tbl_win_port u0 (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .rd_inc(rd_inc),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf(ovf),
        .seq_idx(seq_idx), .seq_data(seq_data)
    );

    function automatic logic [9:0] pat(int i);
        return 10'((i * 37 + 5) & 10'h3FF);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(logic [1:0] a, output logic [7:0] r);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        r = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic srd(int i, output logic [9:0] r);
        @(negedge clk);
        seq_idx = 5'(i);
        @(negedge clk);
        r = seq_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r8;
        logic [9:0] r10;
        logic [9:0] hold;
        repeat (3) @(negedge clk);
        chk("R9 ovf", ovf, 0);
        chk("R9 rdata", bus_rdata, 0);
        chk("R9 seq", seq_data, 0);
        rst_n = 1;

        // Fill every word with writes advancing the pointer (R1 R2 R4).
        io_en = 1; rd_inc = 0;
        for (int b = 0; b < 16; b++) begin
            model[2*b]   = pat(2*b);
            model[2*b+1] = pat(2*b+1);
            bwr(2'd0, {6'b0, model[2*b][1:0]});
            bwr(2'd1, model[2*b][9:2]);
            bwr(2'd2, {6'b0, model[2*b+1][1:0]});
            bwr(2'd3, model[2*b+1][9:2]);
        end
        @(negedge clk);
        chk("R7 ovf set", ovf, 1);
        bwr(2'd0, 8'h01);
        bwr(2'd1, 8'h55);
        brd(2'd1, r8);
        chk("R7 read zero", r8, 0);
        for (int i = 0; i < 32; i++) begin
            srd(i, r10);
            chk("R1 R2 R8 word", r10, model[i]);
        end

        // Disabled window (R3, R7 clear).
        io_en = 0;
        @(negedge clk);
        chk("R7 ovf clear", ovf, 0);
        bwr(2'd0, 8'h01);
        bwr(2'd1, 8'h55);
        brd(2'd1, r8);
        chk("R3 read zero", r8, 0);
        srd(0, r10);
        chk("R3 write ignored", r10, model[0]);

        // Reads do not advance with rd_inc=0 (R4, R6).
        io_en = 1;
        brd(2'd0, r8);
        chk("R6 even", r8, {6'b0, model[0][1:0]});
        brd(2'd1, r8);
        chk("R6 odd", r8, model[0][9:2]);
        @(negedge clk);
        chk("R6 idle zero", bus_rdata, 0);
        brd(2'd3, r8);
        chk("R1 addr3", r8, model[1][9:2]);
        brd(2'd1, r8);
        chk("R4 read no advance", r8, model[0][9:2]);

        // Read-advance mode (R5).
        io_en = 0;
        @(negedge clk);
        io_en = 1; rd_inc = 1;
        bwr(2'd2, 8'h02);
        bwr(2'd3, 8'h3C);
        model[1] = 10'h0F2;
        brd(2'd3, r8);
        chk("R5 write no advance", r8, model[1][9:2]);
        for (int b = 1; b < 16; b++) begin
            brd(2'd0, r8); chk("R5 R6 lo0", r8, {6'b0, model[2*b][1:0]});
            brd(2'd1, r8); chk("R5 R6 hi0", r8, model[2*b][9:2]);
            brd(2'd2, r8); chk("R5 R6 lo1", r8, {6'b0, model[2*b+1][1:0]});
            brd(2'd3, r8); chk("R5 R6 hi1", r8, model[2*b+1][9:2]);
        end
        chk("R7 ovf read mode", ovf, 1);

        // Host priority on the shared port (R8).
        io_en = 0;
        srd(5, hold);
        chk("R8 seq word", hold, model[5]);
        io_en = 1;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 2'd0; seq_idx = 5'd6;
        @(negedge clk);
        chk("R8 seq hold", seq_data, hold);
        bus_sel = 0;
        @(negedge clk);
        chk("R8 seq resume", seq_data, model[6]);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule